// File: doc/BRIEF.md
# Two-Phase Key Matrix Scanner

This block finds a pressed key in a matrix of ROWS row lines and COLS column lines. The block pulls row lines low. The column inputs have pull-ups, so a column reads low only when a closed key joins it to a row that is being pulled low. The block idles in a detect state with every row pulled low and watches the columns. When any column drops, it moves to an identify state. There it pulls one row low at a time, starting at row 0, until a column answers. The key sits where the active row meets the answering column.

A key is accepted only after the same row and column come back from DEBOUNCE consecutive scans. A scan is one detect pass followed by one identify pass. After every change on the row lines, the block waits SETTLE clocks before it samples the columns. The accepted key appears as a one-cycle `key_valid` pulse, with the row and column indices held on the index outputs. The block then waits until every column reads high before it arms again, so a held key gives exactly one report. If several columns are low in the matching row, the lowest column index wins.

The states are `SCAN_ALL` (detect), `SCAN_ROW` (identify) and `WAIT_FREE` (release wait). The transitions are:
- SCAN_ALL→SCAN_ROW when a column is low after settling.
- SCAN_ROW→SCAN_ROW to step to the next row when no column answers.
- SCAN_ROW→SCAN_ALL when a key is found but not yet confirmed, or when the last row gives no answer.
- SCAN_ROW→WAIT_FREE when the key is confirmed and reported.
- WAIT_FREE→SCAN_ALL when all columns are high after settling.

Top module: `keypad_scanner`

## Requirements
- R1: After reset, `key_valid` is 0 and `row_drive_n` is all zeros. Bit r = 0 means row r is pulled low.
- R2: While no column reads low (`col_in` bit c = 0 means column c is low), every row stays pulled low and no report is made.
- R3: At any time, `row_drive_n` is either all zeros or has exactly one zero bit. Single-row steps go upward from row 0.
- R4: The reported `key_row` is the index of the single row that was pulled low when the key was found.
- R5: The reported `key_col` is the lowest index among the columns that read low in that row step.
- R6: Columns are sampled only after `row_drive_n` has been unchanged for SETTLE clocks. The press-to-report latency is therefore at least (2·DEBOUNCE−1)·SETTLE clocks.
- R7: A key is reported only after DEBOUNCE consecutive scans give the same row and column. A shorter press gives no report.
- R8: `key_valid` is a single-cycle pulse. After it, all rows are pulled low, and no further report is made until every column has read high. A key held for a long time gives exactly one report.
- R9: If the identify pass reaches the last row without any column reading low, the block returns to detect, reports nothing and restarts its debounce count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| col_in | input | COLS | Column lines with pull-ups; 0 = pulled low through a key |
| row_drive_n | output | ROWS | Row pull-downs; bit 0 = row pulled low, 1 = released |
| key_valid | output | 1 | One-cycle pulse for an accepted key |
| key_row | output | max(1,clog2(ROWS)) | Row index of the last accepted key |
| key_col | output | max(1,clog2(COLS)) | Column index of the last accepted key |

## Verification
The bench builds a 4×4 matrix with SETTLE=3 and DEBOUNCE=3. At these values a full scan lasts about twenty clocks, so several confirmed presses, brief taps and held keys fit in a short run. The small settle and debounce counts make it possible to tell a tap of a few scans from an accepted press. They also allow the latency lower bound of R6 to be checked against an exact formula. The bench models the matrix from `row_drive_n`, so every row and column corner is reachable, including two keys on one row.

// File: rtl/kpd_pkg.sv
package kpd_pkg;

    typedef enum logic [1:0] {
        SCAN_ALL  = 2'd0,
        SCAN_ROW  = 2'd1,
        WAIT_FREE = 2'd2
    } kpd_state_e;

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/kpd_settle_timer.sv
module kpd_settle_timer #(
    parameter int SETTLE = 8,
    localparam int TW = (SETTLE > 0) ? $clog2(SETTLE + 1) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic settled
);
    logic [TW-1:0] cnt;

    assign settled = (cnt == TW'(SETTLE));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= '0;
        end else if (!settled) begin
            cnt <= cnt + TW'(1);
        end
    end
endmodule

// File: rtl/kpd_low_col_enc.sv
module kpd_low_col_enc #(
    parameter int COLS = 4,
    localparam int CW = (COLS > 1) ? $clog2(COLS) : 1
) (
    input  logic [COLS-1:0] col_n,
    output logic            any_low,
    output logic [CW-1:0]   low_idx
);
    assign any_low = ~&col_n;

    always_comb begin
        low_idx = '0;
        for (int c = COLS - 1; c >= 0; c--) begin
            if (!col_n[c]) begin
                low_idx = CW'(c);
            end
        end
    end
endmodule

// File: rtl/kpd_match_counter.sv
module kpd_match_counter #(
    parameter int ROWS     = 4,
    parameter int COLS     = 4,
    parameter int DEBOUNCE = 4,
    localparam int RW   = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int CW   = (COLS > 1) ? $clog2(COLS) : 1,
    localparam int NW   = $clog2(DEBOUNCE + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          hit,
    input  logic [RW-1:0] hit_row,
    input  logic [CW-1:0] hit_col,
    output logic          would_confirm
);
    logic [RW-1:0] cand_row;
    logic [CW-1:0] cand_col;
    logic [NW-1:0] cnt;
    logic [NW-1:0] next_cnt;
    logic          same;

    assign same          = (cnt != '0) && (cand_row == hit_row) && (cand_col == hit_col);
    assign next_cnt      = same ? (cnt + NW'(1)) : NW'(1);
    assign would_confirm = (int'(next_cnt) >= DEBOUNCE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            cand_row <= '0;
            cand_col <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (hit) begin
            cand_row <= hit_row;
            cand_col <= hit_col;
            cnt      <= would_confirm ? '0 : next_cnt;
        end
    end
endmodule

// File: rtl/keypad_scanner.sv
module keypad_scanner #(
    parameter int ROWS     = 4,
    parameter int COLS     = 4,
    parameter int SETTLE   = 8,
    parameter int DEBOUNCE = 4,
    localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int CW = (COLS > 1) ? $clog2(COLS) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [COLS-1:0] col_in,
    output logic [ROWS-1:0] row_drive_n,
    output logic            key_valid,
    output logic [RW-1:0]   key_row,
    output logic [CW-1:0]   key_col
);
    import kpd_pkg::*;

    localparam logic [RW-1:0] LAST_ROW = RW'(ROWS - 1);

    kpd_state_e    state, state_nxt;
    logic [RW-1:0] row_idx, row_nxt;
    logic          settled, restart;
    logic          any_low;
    logic [CW-1:0] low_idx;
    logic          hit, clr, report, would_confirm;

    kpd_settle_timer #(.SETTLE(SETTLE)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .settled (settled)
    );

    kpd_low_col_enc #(.COLS(COLS)) u_enc (
        .col_n   (col_in),
        .any_low (any_low),
        .low_idx (low_idx)
    );

    kpd_match_counter #(.ROWS(ROWS), .COLS(COLS), .DEBOUNCE(DEBOUNCE)) u_match (
        .clk           (clk),
        .rst_n         (rst_n),
        .clear         (clr),
        .hit           (hit),
        .hit_row       (row_idx),
        .hit_col       (low_idx),
        .would_confirm (would_confirm)
    );

    // next-state and decision logic
    always_comb begin
        state_nxt = state;
        row_nxt   = row_idx;
        hit       = 1'b0;
        clr       = 1'b0;
        report    = 1'b0;
        unique case (state)
            SCAN_ALL: begin
                if (settled) begin
                    if (any_low) begin
                        state_nxt = SCAN_ROW;
                        row_nxt   = '0;
                    end else begin
                        clr = 1'b1;
                    end
                end
            end
            SCAN_ROW: begin
                if (settled) begin
                    if (any_low) begin
                        hit       = 1'b1;
                        report    = would_confirm;
                        state_nxt = would_confirm ? WAIT_FREE : SCAN_ALL;
                    end else if (row_idx == LAST_ROW) begin
                        clr       = 1'b1;
                        state_nxt = SCAN_ALL;
                    end else begin
                        row_nxt = row_idx + RW'(1);
                    end
                end
            end
            WAIT_FREE: begin
                if (settled && !any_low) begin
                    state_nxt = SCAN_ALL;
                end
            end
            default: state_nxt = SCAN_ALL;
        endcase
    end

    assign restart = (state_nxt != state) || (row_nxt != row_idx);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= SCAN_ALL;
            row_idx <= '0;
        end else begin
            state   <= state_nxt;
            row_idx <= row_nxt;
        end
    end

    // registered report outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            key_valid <= 1'b0;
            key_row   <= '0;
            key_col   <= '0;
        end else begin
            key_valid <= report;
            if (report) begin
                key_row <= row_idx;
                key_col <= low_idx;
            end
        end
    end

    // row pull-downs: all rows outside identify, one row inside it
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        assign row_drive_n[r] = !((state != SCAN_ROW) || (row_idx == RW'(r)));
    end
endmodule

// File: rtl/keypad_scanner_chk.sv
module keypad_scanner_chk #(
    parameter int ROWS     = 4,
    parameter int COLS     = 4,
    parameter int SETTLE   = 8,
    parameter int DEBOUNCE = 4,
    localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int CW = (COLS > 1) ? $clog2(COLS) : 1,
    localparam int AW = $clog2(SETTLE + 1)
) (
    input logic            clk,
    input logic            rst_n,
    input logic [COLS-1:0] col_in,
    input logic [ROWS-1:0] row_drive_n,
    input logic            key_valid,
    input logic [RW-1:0]   key_row,
    input logic [CW-1:0]   key_col
);
    logic [ROWS-1:0] rows_q;
    logic [AW-1:0]   age_reg, age_now;

    assign age_now = (row_drive_n != rows_q) ? '0 : age_reg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rows_q  <= '0;
            age_reg <= '0;
        end else begin
            rows_q  <= row_drive_n;
            age_reg <= (age_now == AW'(SETTLE)) ? age_now : age_now + AW'(1);
        end
    end

    // R3
    one_row_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (row_drive_n == '0) || ($countones(~row_drive_n) == 1));

    // R8
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid |=> !key_valid);

    // R8
    release_all_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid |-> (row_drive_n == '0));

    // R4
    row_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid |-> ($past(row_drive_n) == ~(ROWS'(1) << key_row)));

    // R5
    col_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid |-> ((($past(col_in) >> key_col) & COLS'(1)) == '0));

    // R5
    col_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid |-> ((~$past(col_in) & ((COLS'(1) << key_col) - COLS'(1))) == '0));

    // R6
    settle_age_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid |-> ($past(age_now) == AW'(SETTLE)));
endmodule

bind keypad_scanner keypad_scanner_chk #(
    .ROWS(ROWS), .COLS(COLS), .SETTLE(SETTLE), .DEBOUNCE(DEBOUNCE)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .col_in      (col_in),
    .row_drive_n (row_drive_n),
    .key_valid   (key_valid),
    .key_row     (key_row),
    .key_col     (key_col)
);

// File: tb/keypad_scanner_test.sv
module keypad_scanner_test;
    localparam int ROWS = 4;
    localparam int COLS = 4;
    localparam int SETTLE = 3;
    localparam int DEBOUNCE = 3;
    localparam int MIN_LAT = (2 * DEBOUNCE - 1) * SETTLE;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [COLS-1:0] col_in;
    logic [ROWS-1:0] row_drive_n;
    logic            key_valid;
    logic [1:0]      key_row;
    logic [1:0]      key_col;
    logic [ROWS*COLS-1:0] pressed = '0;

    int checks = 0, failures = 0;
    int cyc = 0, n_rep = 0, last_row = 0, last_col = 0, last_t = 0, bad_rows = 0;
    bit done = 0;

    always #4 clk = ~clk;

    keypad_scanner #(.ROWS(ROWS), .COLS(COLS), .SETTLE(SETTLE), .DEBOUNCE(DEBOUNCE)) uut (
        .clk(clk), .rst_n(rst_n), .col_in(col_in), .row_drive_n(row_drive_n),
        .key_valid(key_valid), .key_row(key_row), .key_col(key_col)
    );

    // key matrix model: column pulled low by any closed key on a pulled-low row
    always_comb begin
        col_in = '1;
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++)
                if (pressed[r*COLS+c] && !row_drive_n[r]) col_in[c] = 1'b0;
    end

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) if (rst_n) begin
        if (key_valid) begin
            n_rep++; last_row = int'(key_row); last_col = int'(key_col); last_t = cyc;
        end
        if (!(row_drive_n == '0 || $countones(~row_drive_n) == 1)) bad_rows++;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int lowest_col(input int mask);
        for (int c = 0; c < COLS; c++) if (mask[c]) return c;
        return -1;
    endfunction

    // press keys of one row given by a column mask, hold, release, wait
    task automatic press_row(input int r, input int cmask, input int hold, input int gap,
                             input bit expect_rep, input string req);
        int base, t0;
        base = n_rep;
        @(negedge clk);
        t0 = cyc;
        for (int c = 0; c < COLS; c++) if (cmask[c]) pressed[r*COLS+c] = 1'b1;
        repeat (hold) @(negedge clk);
        pressed = '0;
        repeat (gap) @(negedge clk);
        if (expect_rep) begin
            check(n_rep - base == 1, {req, " R8 report count"}, n_rep - base, 1);
            check(last_row == r, {req, " R4 row"}, last_row, r);
            check(last_col == lowest_col(cmask), {req, " R5 col"}, last_col, lowest_col(cmask));
            check(last_t - t0 >= MIN_LAT, {req, " R6 latency"}, last_t - t0, MIN_LAT);
        end else begin
            check(n_rep == base, {req, " R7 R9 no report"}, n_rep - base, 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++; checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R1 reset state
        check(key_valid == 1'b0, "R1 key_valid", int'(key_valid), 0);
        check(row_drive_n == '0, "R1 rows", int'(row_drive_n), 0);
        rst_n = 1'b1;
        // R2 idle: rows all low, no report
        for (int i = 0; i < 5; i++) begin
            repeat (9) @(negedge clk);
            check(row_drive_n == '0, "R2 idle rows", int'(row_drive_n), 0);
        end
        check(n_rep == 0, "R2 idle reports", n_rep, 0);

        // directed corners
        press_row(0, 4'b0001, 250, 60, 1'b1, "corner r0c0");
        press_row(3, 4'b1000, 250, 60, 1'b1, "corner r3c3");
        press_row(2, 4'b1010, 250, 60, 1'b1, "two keys same row");
        press_row(1, 4'b0100, 10, 60, 1'b0, "short tap");
        press_row(3, 4'b0001, 25, 60, 1'b0, "short tap late row");
        press_row(1, 4'b0010, 1500, 60, 1'b1, "long hold R8");

        // random presses
        for (int k = 0; k < 10; k++) begin
            int r, c, hold;
            r = int'($urandom_range(ROWS - 1));
            c = int'($urandom_range(COLS - 1));
            hold = int'($urandom_range(400, 200));
            press_row(r, 1 << c, hold, 60, 1'b1, "random");
        end

        // R3 row pattern observed throughout
        check(bad_rows == 0, "R3 row pattern", bad_rows, 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule